// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Selectable Framing

This block sends bytes out on one serial line. A host writes a byte into a parallel holding register. On a baud tick, the byte moves into a shift register whenever the shifter is idle or is just finishing its last bit. Because of this two-stage path, the next byte can wait while the current one is being sent, and frames then follow each other with no idle time between them. A flag tells the host when the holding register can take a new byte. A second flag tells it when the line has gone quiet after the last frame.

A four-bit mode field, written through the same port, picks the line format. Asynchronous framing uses a low start bit, 7 or 8 data bits sent least significant bit first, an optional even or odd parity bit, and one high stop bit. Clocked synchronous transfer sends 8 bits with a serial clock and no framing bits. The baud tick comes from outside the block. The mode is taken when a byte enters the shifter, so a mode write during a frame only affects later frames.

Top module: `ser_tx_core`

## Requirements
- R1: After reset the holding register reads 0xFF, the empty flag is 1 and the transmit-end flag is 1. The mode field is 0, so a byte sent without any mode write goes out as 8 data bits in asynchronous framing with no parity.
- R2: A byte in the holding register is moved into the shifter at the first tick on which the shifter is idle or finishing its last bit. The empty flag is 1 from that edge on.
- R3: If a byte is waiting when a frame's last bit ends, its first bit starts on the very next tick slot, with no idle slot in between.
- R4: With write-data bit 7 of the mode write at 0 (asynchronous), a frame is: start bit 0, the data bits least significant first, then stop bit 1. Each bit lasts one tick period and changes only on a tick.
- R5: With mode bit 6 at 1 in asynchronous mode, only data bits 0 to 6 are sent. Data bit 7 does not appear on the line.
- R6: With mode bit 5 at 1 in asynchronous mode, a parity bit follows the data bits. Mode bit 4 at 0 gives even parity over the sent data bits, and at 1 gives odd parity.
- R7: With mode bit 7 at 1, the 8 data bits are sent least significant first with no start, stop or parity bit, and mode bits 6 to 4 are ignored. Each bit lasts two ticks. The serial clock is 0 during the first tick of each bit and 1 during the second.
- R8: The transmit-end flag goes to 1 when a frame's last bit ends with no byte waiting. It goes to 0 when a byte enters the shifter, and it is 0 whenever a frame is in progress.
- R9: A mode write made while a frame is being sent does not change that frame. It applies to the next byte that enters the shifter.
- R10: With no frame in progress, the serial data line and the serial clock are both 1.
- R11: A write with wr_sel=0 stores wr_data in the holding register (visible on hold_byte_o) and sets the empty flag to 0 from the next cycle. A write with wr_sel=1 stores wr_data[7:4] as the mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the holding register, 1 selects the mode field |
| wr_data | input | 8 | Write data |
| bit_tick | input | 1 | One-cycle baud tick |
| txd_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Serial clock, used in synchronous mode |
| hold_byte_o | output | 8 | Current contents of the holding register |
| hold_empty_o | output | 1 | Holding register can accept a byte |
| tx_end_o | output | 1 | Line idle with nothing pending |

## Verification
The hardest case to reach is the handover at the end of a frame: the last bit ends on the same tick that loads the waiting byte. Here the shifter must neither drop back to idle for a slot nor set the transmit-end flag. The stimulus writes the next byte right after it sees the current frame's first bit. This guarantees that every sequence of more than one frame crosses this boundary, and the bench checks every tick slot across it. Mode writes placed in the middle of a frame, followed by a waiting byte, also test that the format is captured at the moment the byte is loaded.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int MODE_LSB = 4;

  typedef struct packed {
    logic sync;
    logic short_char;
    logic par_en;
    logic par_odd;
  } mode_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [LEN_W-1:0]   len;
  } frame_t;

  function automatic int char_bits(input mode_t m);
    return (m.short_char && !m.sync) ? DATA_W - 1 : DATA_W;
  endfunction

  function automatic logic parity_of(input mode_t m, input logic [DATA_W-1:0] d);
    logic p;
    p = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < char_bits(m)) p = p ^ d[i];
    return p ^ m.par_odd;
  endfunction

  function automatic frame_t frame_build(input mode_t m, input logic [DATA_W-1:0] d);
    frame_t fb;
    int     n;
    int     pos;
    fb.bits = '1;
    if (m.sync) begin
      fb.bits[DATA_W-1:0] = d;
      fb.len = LEN_W'(DATA_W);
    end else begin
      n = char_bits(m);
      fb.bits[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++)
        if (i < n) fb.bits[i+1] = d[i];
      pos = n + 1;
      if (m.par_en) begin
        fb.bits[pos] = parity_of(m, d);
        pos = pos + 1;
      end
      fb.bits[pos] = 1'b1;
      fb.len = LEN_W'(pos + 1);
    end
    return fb;
  endfunction
endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold
  import ser_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_q,
  output logic              hold_empty,
  output mode_t             mode_q,
  output logic              data_wr_evt
);
  logic mode_wr_evt;

  assign data_wr_evt = wr_en && !wr_sel;
  assign mode_wr_evt = wr_en && wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '1;
      hold_empty <= 1'b1;
    end else if (data_wr_evt) begin
      hold_q     <= wr_data;
      hold_empty <= 1'b0;
    end else if (take) begin
      hold_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (mode_wr_evt) mode_q <= mode_t'(wr_data[DATA_W-1:MODE_LSB]);
  end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
  import ser_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  mode_t             mode,
  output logic              load_evt,
  output logic              frame_end_evt,
  output logic              busy,
  output logic              sync_active,
  output logic              txd,
  output logic              sclk,
  output logic              tx_end
);
  logic [FRAME_W-1:0] frame_q;
  logic [LEN_W-1:0]   left_q;
  logic               sync_q;
  logic               phase_q;
  logic               adv;
  logic               half;
  frame_t             next_frame;

  assign next_frame    = frame_build(mode, hold_data);
  assign adv           = bit_tick && busy && (!sync_q || phase_q);
  assign half          = bit_tick && busy && sync_q && !phase_q;
  assign frame_end_evt = adv && (left_q == LEN_W'(1));
  assign load_evt      = bit_tick && hold_full && (!busy || frame_end_evt);
  assign sync_active   = busy && sync_q;
  assign txd           = busy ? frame_q[0] : 1'b1;
  assign sclk          = !(sync_active && !phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      frame_q <= '1;
      left_q  <= '0;
      sync_q  <= 1'b0;
      phase_q <= 1'b0;
      tx_end  <= 1'b1;
    end else if (load_evt) begin
      frame_q <= next_frame.bits;
      left_q  <= next_frame.len;
      busy    <= 1'b1;
      sync_q  <= mode.sync;
      phase_q <= 1'b0;
      tx_end  <= 1'b0;
    end else if (frame_end_evt) begin
      busy    <= 1'b0;
      phase_q <= 1'b0;
      tx_end  <= 1'b1;
    end else if (adv) begin
      frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
      left_q  <= left_q - LEN_W'(1);
      phase_q <= 1'b0;
    end else if (half) begin
      phase_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ser_tx_core.sv
module ser_tx_core
  import ser_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       bit_tick,
  output logic       txd_o,
  output logic       sclk_o,
  output logic [7:0] hold_byte_o,
  output logic       hold_empty_o,
  output logic       tx_end_o
);
  logic              load_w;
  logic              frame_end_w;
  logic              busy_w;
  logic              sync_active_w;
  logic              data_wr_w;
  logic              hold_empty_w;
  logic [DATA_W-1:0] hold_w;
  mode_t             mode_w;

  ser_tx_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .take        (load_w),
    .hold_q      (hold_w),
    .hold_empty  (hold_empty_w),
    .mode_q      (mode_w),
    .data_wr_evt (data_wr_w)
  );

  ser_tx_shift u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_tick      (bit_tick),
    .hold_full     (!hold_empty_w),
    .hold_data     (hold_w),
    .mode          (mode_w),
    .load_evt      (load_w),
    .frame_end_evt (frame_end_w),
    .busy          (busy_w),
    .sync_active   (sync_active_w),
    .txd           (txd_o),
    .sclk          (sclk_o),
    .tx_end        (tx_end_o)
  );

  assign hold_byte_o  = hold_w;
  assign hold_empty_o = hold_empty_w;
endmodule

// File: rtl/ser_tx_core_chk.sv
module ser_tx_core_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic txd,
  input logic sclk,
  input logic hold_empty,
  input logic tx_end,
  input logic busy,
  input logic sync_active,
  input logic load_evt,
  input logic data_wr_evt,
  input logic mode_sync_now
);
  AST_TXD_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd)); // R4
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !mode_sync_now |=> !txd); // R4
  AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !hold_empty); // R2
  AST_LOAD_FREES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !data_wr_evt |=> hold_empty); // R2
  AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_evt |=> !hold_empty); // R11
  AST_END_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> !busy); // R8
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd && sclk); // R10
  AST_CLOCK_ONLY_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_active |-> sclk); // R7
endmodule

bind ser_tx_core ser_tx_core_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_tick      (bit_tick),
  .txd           (txd_o),
  .sclk          (sclk_o),
  .hold_empty    (hold_empty_o),
  .tx_end        (tx_end_o),
  .busy          (busy_w),
  .sync_active   (sync_active_w),
  .load_evt      (load_w),
  .data_wr_evt   (data_wr_w),
  .mode_sync_now (mode_w.sync)
);

// File: tb/ser_tx_core_bench.sv
module ser_tx_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       bit_tick = 1'b0;
  logic       txd_o, sclk_o, hold_empty_o, tx_end_o;
  logic [7:0] hold_byte_o;

  int total = 0;
  int failed = 0;
  int tick_cnt = 0;
  logic [7:0] seq_b [0:3];
  string tag_ovr = "";

  ser_tx_core u_ser_tx_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bit_tick(bit_tick), .txd_o(txd_o), .sclk_o(sclk_o), .hold_byte_o(hold_byte_o),
    .hold_empty_o(hold_empty_o), .tx_end_o(tx_end_o)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt == 4) ? 0 : tick_cnt + 1;
    bit_tick <= (tick_cnt == 4);
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_nbits(input logic [7:0] m);
    if (m[7]) return 8;
    return m[6] ? 7 : 8;
  endfunction

  function automatic int exp_len(input logic [7:0] m);
    if (m[7]) return 8;
    return exp_nbits(m) + 2 + (m[5] ? 1 : 0);
  endfunction

  function automatic logic exp_bit(input logic [7:0] m, input logic [7:0] d, input int i);
    int n;
    int ones;
    if (m[7]) return d[i];
    n = exp_nbits(m);
    if (i == 0) return 1'b0;
    if (i <= n) return d[i-1];
    if (m[5] && i == n + 1) begin
      ones = 0;
      for (int j = 0; j < n; j++) ones += d[j];
      return (ones % 2 == 1) ? !m[4] : m[4];
    end
    return 1'b1;
  endfunction

  function automatic string slot_tag(input logic [7:0] m, input int k, input int i);
    if (tag_ovr != "") return tag_ovr;
    if (k > 0 && i == 0) return "R3";
    if (m[7]) return "R7";
    if (m[5] && i == exp_nbits(m) + 1) return "R6";
    if (m[6]) return "R5";
    return "R4";
  endfunction

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (bit_tick !== 1'b1);
    @(negedge clk);
  endtask

  task automatic run_seq(input logic [7:0] m, input bit set_mode, input int nfr,
                         input bit mid_chg, input logic [7:0] m2);
    logic [7:0] cur_m;
    logic [7:0] next_m;
    if (set_mode) wr(1'b1, m);
    chk(hold_empty_o === 1'b1, "R11", hold_empty_o, 1);
    wr(1'b0, seq_b[0]);
    chk(hold_empty_o === 1'b0, "R11", hold_empty_o, 0);
    chk(hold_byte_o === seq_b[0], "R11", hold_byte_o, seq_b[0]);
    cur_m = m;
    next_m = m;
    for (int k = 0; k < nfr; k++) begin
      cur_m = next_m;
      for (int i = 0; i < exp_len(cur_m); i++) begin
        for (int ph = 0; ph < (cur_m[7] ? 2 : 1); ph++) begin
          wait_tick();
          chk(txd_o === exp_bit(cur_m, seq_b[k], i), slot_tag(cur_m, k, i),
              txd_o, exp_bit(cur_m, seq_b[k], i));
          if (cur_m[7]) chk(sclk_o === ph[0], "R7", sclk_o, ph);
          else chk(sclk_o === 1'b1, "R10", sclk_o, 1);
          chk(tx_end_o === 1'b0, "R8", tx_end_o, 0);
          if (i == 0 && ph == 0) begin
            chk(hold_empty_o === 1'b1, "R2", hold_empty_o, 1);
            if (k + 1 < nfr) wr(1'b0, seq_b[k+1]);
            if (mid_chg && k == 0) begin
              wr(1'b1, m2);
              next_m = m2;
            end
          end
        end
      end
    end
    wait_tick();
    chk(txd_o === 1'b1, "R10", txd_o, 1);
    chk(sclk_o === 1'b1, "R10", sclk_o, 1);
    chk(tx_end_o === 1'b1, "R8", tx_end_o, 1);
    chk(hold_empty_o === 1'b1, "R2", hold_empty_o, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hold_byte_o === 8'hFF, "R1", hold_byte_o, 8'hFF);
    chk(hold_empty_o === 1'b1, "R1", hold_empty_o, 1);
    chk(tx_end_o === 1'b1, "R1", tx_end_o, 1);
    chk(txd_o === 1'b1, "R10", txd_o, 1);
    chk(sclk_o === 1'b1, "R10", sclk_o, 1);

    // R1: reset mode gives 8-bit async without parity
    seq_b[0] = 8'hA5;
    tag_ovr = "R1";
    run_seq(8'h00, 1'b0, 1, 1'b0, 8'h00);
    tag_ovr = "";

    // R3 R4: back-to-back 8-bit frames
    seq_b[0] = 8'h3C; seq_b[1] = 8'hC3; seq_b[2] = 8'h01;
    run_seq(8'h00, 1'b1, 3, 1'b0, 8'h00);
    // R5: 7-bit character drops data bit 7
    seq_b[0] = 8'hC1; seq_b[1] = 8'h80;
    run_seq(8'h40, 1'b1, 2, 1'b0, 8'h00);
    // R6: even then odd parity
    seq_b[0] = 8'h07; seq_b[1] = 8'h00;
    run_seq(8'h20, 1'b1, 2, 1'b0, 8'h00);
    run_seq(8'h30, 1'b1, 2, 1'b0, 8'h00);
    seq_b[0] = 8'hFE;
    run_seq(8'h70, 1'b1, 1, 1'b0, 8'h00);
    // R7: synchronous, bits 6..4 ignored
    seq_b[0] = 8'h96; seq_b[1] = 8'h5A; seq_b[2] = 8'hFF;
    run_seq(8'hF0, 1'b1, 3, 1'b0, 8'h00);
    // R9: mode change mid-frame affects only the next frame
    seq_b[0] = 8'h6D;
    tag_ovr = "R9";
    run_seq(8'h00, 1'b1, 1, 1'b1, 8'h80);
    seq_b[0] = 8'h2B; seq_b[1] = 8'hB2;
    run_seq(8'h80, 1'b1, 2, 1'b1, 8'h30);
    tag_ovr = "";

    for (int r = 0; r < 25; r++) begin
      logic [7:0] m;
      int nf;
      m = 8'($urandom()) & 8'hF0;
      nf = 1 + int'($urandom() % 3);
      for (int b = 0; b < 4; b++) seq_b[b] = 8'($urandom());
      run_seq(m, 1'b1, nf, 1'b0, 8'h00);
    end

    summary();
    $finish;
  end
endmodule